// File: doc/BRIEF.md
# Key-Protected DRAM Controller Configuration Register File

This block is the register bank that sits in front of a DRAM controller's control space. Software reaches it through a simple word-wide bus made of an address, a write strobe, write data and read data. A dedicated key register at word 0 guards the bank. The value written there moves a three-state lock machine:

- `LK_OPEN`: every register can be written.
- `LK_SOFT`: only the key register and a small group of always-free registers can be written.
- `LK_HARD`: only the free group can be written, and this state holds until reset.

A few registers have bits that the bank fixes on every write. The configuration word carries a version, a size code and an aperture field. A PHY status word never reads busy and always reads PLL-locked. A self-test control word always reads finished and never reads failed. This lets boot code run its polling loops without a real DRAM interface behind the bank.

A write can be refused for three reasons: the lock state blocks it, the address is not word-aligned, or the address is past the register array. A refused write has no effect, and the bank raises a one-cycle error pulse. A read at such an address returns zero. The lock states and their transitions are:

- `LK_SOFT` is the reset state.
- `KEY_OPEN` (write 0xFC600309) goes to `LK_OPEN`.
- `KEY_HARD` (write 0xDEADDEAD) goes to `LK_HARD`.
- Any other key value goes to `LK_SOFT`.
- `LK_HARD` has no exit other than reset.

Top module: `sdmc_keyed_regfile`

## Requirements
- R1: After reset the key word (byte 0x000) reads 0x00. The configuration word (0x004) reads {VERSION, 24'h0, 2'b11, SIZE_CODE}. Word index 0x100 reads 0x2, index 0x114 reads 0x0FFFFFFF, and indexes 0x11A and 0x11F read 0xFF. Every other word reads 0.
- R2: Writing 0xFC600309 to byte 0x000, while not hard-locked, makes the key word read 0x01 (open). While open, every in-range aligned write takes effect.
- R3: Writing 0xDEADDEAD to byte 0x000, while open, makes the key word read 0x10 (hard). From then until reset, every write outside the free group is ignored, including a write to 0x000.
- R4: Writing any other value to 0x000, while open or soft, makes the key word read 0x00 (soft). While soft, writes outside the free group and other than to 0x000 are ignored.
- R5: Byte offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 accept writes in all three lock states.
- R6: A write to 0x004 stores the data with these changes:
  - Bits 31:28 are forced to VERSION.
  - Bits 3:2 are forced to 2'b11.
  - Bits 1:0 are forced to SIZE_CODE.
  - Bits 19, 18:14 and 6 are cleared.
- R7: A write to 0x060 stores the data with bit 0 forced to 0 and bit 4 forced to 1.
- R8: A write to 0x070 stores the data with bit 12 forced to 1 and bit 13 forced to 0.
- R9: For an address whose word index is NUM_WORDS or more, a read returns 0 and a write changes nothing.
- R10: For an address with a nonzero value in bits 1:0, a read returns 0 and a write changes nothing.
- R11: `err` is high for exactly the one cycle after a write that was refused (R3, R4, R9, R10). It stays low after an accepted write.
- R12: Reads are combinational from `addr`. An accepted write is visible on `rdata` from the cycle after its clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Byte address within the 4 KiB window |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| err | output | 1 | One-cycle pulse after a refused write |

## Verification
A wrong lock state shows on the very next read of byte 0x000, because that read returns the state's encoding. It also shows one cycle after the next protected write, when `err` disagrees with the expected acceptance and the target word reads back wrong. A fault in the write shaping only shows once the shaped register has been written and read back, so each forced field is checked with all-ones and all-zeros data. A stale hard lock is caught right after reset, when the key word must read 0x00 again.

// File: rtl/sdmc_regs_pkg.sv
package sdmc_regs_pkg;

    typedef enum logic [1:0] {
        LK_SOFT = 2'd0,
        LK_OPEN = 2'd1,
        LK_HARD = 2'd2
    } lock_state_t;

    localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
    localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;

    localparam logic [31:0] CODE_SOFT = 32'h0000_0000;
    localparam logic [31:0] CODE_OPEN = 32'h0000_0001;
    localparam logic [31:0] CODE_HARD = 32'h0000_0010;

    // word indexes with special behaviour
    localparam int IDX_KEY     = 'h00;
    localparam int IDX_CONF    = 'h01;
    localparam int IDX_PHYSTAT = 'h18;
    localparam int IDX_TESTCTL = 'h1C;

    // words writable regardless of lock state
    localparam int N_FREE = 8;
    localparam int FREE_IDX [N_FREE] = '{'h14, 'h1B, 'h1D, 'h1E, 'h1F, 'h22, 'h23, 'h2D};

    // configuration word bits cleared before fixed fields are merged
    localparam logic [31:0] CONF_RO_MASK = 32'hF00F_C04F;

endpackage

// File: rtl/sdmc_lock_fsm.sv
module sdmc_lock_fsm
    import sdmc_regs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic [31:0] key_data,
    output lock_state_t state,
    output logic [31:0] key_code
);

    lock_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_SOFT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN, LK_SOFT: begin
                if (key_wr) begin
                    if (key_data == KEY_OPEN)      state_d = LK_OPEN;
                    else if (key_data == KEY_HARD) state_d = LK_HARD;
                    else                           state_d = LK_SOFT;
                end
            end
            LK_HARD: state_d = LK_HARD;
            default: state_d = LK_SOFT;
        endcase
    end

    always_comb begin
        unique case (state_q)
            LK_OPEN: key_code = CODE_OPEN;
            LK_HARD: key_code = CODE_HARD;
            default: key_code = CODE_SOFT;
        endcase
    end

    assign state = state_q;

endmodule

// File: rtl/sdmc_access_gate.sv
module sdmc_access_gate
    import sdmc_regs_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int NUM_WORDS = 288,
    localparam int IDX_W    = ADDR_W - 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  lock_state_t       state,
    output logic [IDX_W-1:0]  idx,
    output logic              in_range,
    output logic              is_key,
    output logic              key_wr,
    output logic              reg_wr,
    output logic              drop
);

    logic free_hit;
    logic lock_ok;

    assign idx      = addr[ADDR_W-1:2];
    assign in_range = (addr[1:0] == 2'b00) && (32'(idx) < NUM_WORDS);
    assign is_key   = (32'(idx) == IDX_KEY);

    always_comb begin
        free_hit = 1'b0;
        for (int k = 0; k < N_FREE; k++) begin
            if (32'(idx) == FREE_IDX[k]) free_hit = 1'b1;
        end
    end

    always_comb begin
        unique case (state)
            LK_OPEN: lock_ok = 1'b1;
            LK_SOFT: lock_ok = is_key || free_hit;
            LK_HARD: lock_ok = free_hit;
            default: lock_ok = free_hit;
        endcase
    end

    assign key_wr = wr_en && in_range && lock_ok && is_key;
    assign reg_wr = wr_en && in_range && lock_ok && !is_key;
    assign drop   = wr_en && !(in_range && lock_ok);

endmodule

// File: rtl/sdmc_write_shaper.sv
module sdmc_write_shaper
    import sdmc_regs_pkg::*;
#(
    parameter int IDX_W               = 10,
    parameter logic [3:0] VERSION     = 4'h3,
    parameter logic [1:0] SIZE_CODE   = 2'b01,
    localparam logic [31:0] CONF_FIX  = {VERSION, 24'h0, 2'b11, SIZE_CODE}
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      din,
    output logic [31:0]      dout
);

    always_comb begin
        dout = din;
        if (32'(idx) == IDX_CONF) begin
            dout = (din & ~CONF_RO_MASK) | CONF_FIX;
        end else if (32'(idx) == IDX_PHYSTAT) begin
            dout    = din;
            dout[0] = 1'b0;
            dout[4] = 1'b1;
        end else if (32'(idx) == IDX_TESTCTL) begin
            dout     = din;
            dout[12] = 1'b1;
            dout[13] = 1'b0;
        end
    end

endmodule

// File: rtl/sdmc_reg_array.sv
module sdmc_reg_array #(
    parameter int NUM_WORDS           = 288,
    parameter int IDX_W               = 10,
    parameter logic [31:0] CONF_RESET = 32'h3000_000D
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] idx,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_data
);

    logic [31:0] mem [NUM_WORDS];

    function automatic logic [31:0] reset_word(input int i);
        case (i)
            'h001:   return CONF_RESET;
            'h100:   return 32'h0000_0002;
            'h114:   return 32'h0FFF_FFFF;
            'h11A:   return 32'h0000_00FF;
            'h11F:   return 32'h0000_00FF;
            default: return 32'h0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_WORDS; i++) mem[i] <= reset_word(i);
        end else if (we && (32'(idx) < NUM_WORDS)) begin
            mem[idx] <= wdata;
        end
    end

    assign rd_data = (32'(idx) < NUM_WORDS) ? mem[idx] : 32'h0;

endmodule

// File: rtl/sdmc_keyed_regfile.sv
module sdmc_keyed_regfile
    import sdmc_regs_pkg::*;
#(
    parameter int ADDR_W            = 12,
    parameter int NUM_WORDS         = 288,
    parameter logic [3:0] VERSION   = 4'h3,
    parameter logic [1:0] SIZE_CODE = 2'b01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err
);

    localparam int IDX_W = ADDR_W - 2;
    localparam logic [31:0] CONF_RESET = {VERSION, 24'h0, 2'b11, SIZE_CODE};

    lock_state_t      lock_state;
    logic [31:0]      key_code;
    logic [IDX_W-1:0] idx;
    logic             in_range, is_key, key_wr, reg_wr, drop;
    logic [31:0]      shaped;
    logic [31:0]      arr_rd;
    logic             err_q;

    sdmc_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (key_wr),
        .key_data (wdata),
        .state    (lock_state),
        .key_code (key_code)
    );

    sdmc_access_gate #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS)) u_gate (
        .addr     (addr),
        .wr_en    (wr_en),
        .state    (lock_state),
        .idx      (idx),
        .in_range (in_range),
        .is_key   (is_key),
        .key_wr   (key_wr),
        .reg_wr   (reg_wr),
        .drop     (drop)
    );

    sdmc_write_shaper #(.IDX_W(IDX_W), .VERSION(VERSION), .SIZE_CODE(SIZE_CODE)) u_shape (
        .idx  (idx),
        .din  (wdata),
        .dout (shaped)
    );

    sdmc_reg_array #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W), .CONF_RESET(CONF_RESET)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (reg_wr),
        .idx     (idx),
        .wdata   (shaped),
        .rd_data (arr_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= drop;
    end

    always_comb begin
        if (!in_range)   rdata = 32'h0;
        else if (is_key) rdata = key_code;
        else             rdata = arr_rd;
    end

    assign err = err_q;

endmodule

// File: rtl/sdmc_keyed_regfile_chk.sv
module sdmc_keyed_regfile_chk
    import sdmc_regs_pkg::*;
#(
    parameter int ADDR_W            = 12,
    parameter int NUM_WORDS         = 288,
    parameter logic [3:0] VERSION   = 4'h3,
    parameter logic [1:0] SIZE_CODE = 2'b01
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       rdata,
    input logic              err,
    input lock_state_t       lock_state
);

    logic addr_ok;
    assign addr_ok = (addr[1:0] == 2'b00) && (32'(addr[ADDR_W-1:2]) < NUM_WORDS);

    assert_hard_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_state == LK_HARD) |=> (lock_state == LK_HARD));

    assert_key_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == '0) |-> (rdata == 32'h0 || rdata == 32'h1 || rdata == 32'h10));

    assert_conf_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'(4)) |-> (rdata[31:28] == VERSION && rdata[3:0] == {2'b11, SIZE_CODE}
                                  && !rdata[19] && !rdata[6]));

    assert_phy_not_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'('h60)) |-> !rdata[0]);

    assert_test_no_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'('h70)) |-> !rdata[13]);

    assert_bad_addr_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |-> (rdata == 32'h0));

    assert_err_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_en));

    assert_open_no_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr_ok && lock_state == LK_OPEN) |=> !err);

endmodule

bind sdmc_keyed_regfile sdmc_keyed_regfile_chk #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .VERSION(VERSION), .SIZE_CODE(SIZE_CODE)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (addr),
    .wr_en      (wr_en),
    .rdata      (rdata),
    .err        (err),
    .lock_state (lock_state)
);

// File: tb/test_sdmc_keyed_regfile.sv
module test_sdmc_keyed_regfile;

    localparam int AW = 12;
    localparam logic [31:0] K_OPEN = 32'hFC60_0309;
    localparam logic [31:0] K_HARD = 32'hDEAD_DEAD;
    localparam logic [31:0] CONF0  = 32'h3000_000D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic          err;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sdmc_keyed_regfile #(.ADDR_W(AW), .NUM_WORDS(288), .VERSION(4'h3), .SIZE_CODE(2'b01)) i_sdmc_keyed_regfile (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .err(err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, output logic e);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        e = err;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset_defaults();
        logic [31:0] d;
        rd(12'h000, d); check("R1 key after reset", d, 32'h0);
        rd(12'h004, d); check("R1 conf after reset", d, CONF0);
        rd(12'h400, d); check("R1 phy 0x100", d, 32'h2);
        rd(12'h450, d); check("R1 phy 0x114", d, 32'h0FFF_FFFF);
        rd(12'h468, d); check("R1 phy 0x11A", d, 32'hFF);
        rd(12'h47C, d); check("R1 phy 0x11F", d, 32'hFF);
        rd(12'h008, d); check("R1 plain word zero", d, 32'h0);
        check("R1 err low", {31'h0, err}, 32'h0);
    endtask

    task automatic t_soft_drop();
        logic e; logic [31:0] d;
        wr(12'h008, 32'h1234_5678, e); check("R4 soft drop err", {31'h0, e}, 32'h1);
        rd(12'h008, d); check("R4 soft drop data", d, 32'h0);
        check("R11 err one cycle", {31'h0, err}, 32'h0);
        wr(12'h004, 32'h0000_0000, e); rd(12'h004, d); check("R4 conf kept", d, CONF0);
    endtask

    task automatic t_unlock_write();
        logic e; logic [31:0] d;
        wr(12'h000, K_OPEN, e); check("R2 key accepted", {31'h0, e}, 32'h0);
        rd(12'h000, d); check("R2 open code", d, 32'h1);
        wr(12'h008, 32'hA5A5_5A5A, e); check("R11 no err open", {31'h0, e}, 32'h0);
        rd(12'h008, d); check("R2 R12 open write", d, 32'hA5A5_5A5A);
    endtask

    task automatic t_shaping();
        logic e; logic [31:0] d;
        wr(12'h004, 32'hFFFF_FFFF, e); rd(12'h004, d); check("R6 conf ones", d, 32'h3FF0_3FBD);
        wr(12'h004, 32'h0000_0000, e); rd(12'h004, d); check("R6 conf zeros", d, CONF0);
        wr(12'h060, 32'hFFFF_FFFF, e); rd(12'h060, d); check("R7 status ones", d, 32'hFFFF_FFFE);
        wr(12'h060, 32'h0000_0000, e); rd(12'h060, d); check("R7 status zeros", d, 32'h10);
        wr(12'h070, 32'h0000_0000, e); rd(12'h070, d); check("R8 test zeros", d, 32'h1000);
        wr(12'h070, 32'hFFFF_FFFF, e); rd(12'h070, d); check("R8 test ones", d, 32'hFFFF_DFFF);
    endtask

    task automatic t_relock_and_free();
        logic e; logic [31:0] d;
        logic [AW-1:0] fr [8] = '{12'h050, 12'h06C, 12'h074, 12'h078, 12'h07C, 12'h088, 12'h08C, 12'h0B4};
        wr(12'h000, 32'h1234_5678, e); rd(12'h000, d); check("R4 other key soft", d, 32'h0);
        wr(12'h00C, 32'h0000_0077, e); check("R4 relock err", {31'h0, e}, 32'h1);
        rd(12'h00C, d); check("R4 relock drop", d, 32'h0);
        for (int k = 0; k < 8; k++) begin
            wr(fr[k], 32'hC0DE_0000 | 32'(k), e);
            check("R5 free no err", {31'h0, e}, 32'h0);
            rd(fr[k], d); check("R5 free write soft", d, 32'hC0DE_0000 | 32'(k));
        end
    endtask

    task automatic t_bad_address();
        logic e; logic [31:0] d;
        wr(12'h000, K_OPEN, e);
        wr(12'h480, 32'hFFFF_FFFF, e); check("R9 oor err", {31'h0, e}, 32'h1);
        rd(12'h480, d); check("R9 oor read", d, 32'h0);
        rd(12'hFFC, d); check("R9 top read", d, 32'h0);
        wr(12'h010, 32'h0000_1111, e);
        wr(12'h012, 32'h0000_2222, e); check("R10 misaligned err", {31'h0, e}, 32'h1);
        rd(12'h010, d); check("R10 word untouched", d, 32'h1111);
        rd(12'h012, d); check("R10 misaligned read", d, 32'h0);
    endtask

    task automatic t_hard_lock();
        logic e; logic [31:0] d;
        wr(12'h000, K_HARD, e); rd(12'h000, d); check("R3 hard code", d, 32'h10);
        wr(12'h000, K_OPEN, e); check("R3 key refused err", {31'h0, e}, 32'h1);
        rd(12'h000, d); check("R3 stays hard", d, 32'h10);
        wr(12'h008, 32'h0, e); rd(12'h008, d); check("R3 protected kept", d, 32'hA5A5_5A5A);
        wr(12'h0B4, 32'h600D_F00D, e); rd(12'h0B4, d); check("R5 free write hard", d, 32'h600D_F00D);
        do_reset();
        rd(12'h000, d); check("R1 reset clears hard", d, 32'h0);
    endtask

    initial begin
        do_reset();
        t_reset_defaults();
        t_soft_drop();
        t_unlock_write();
        t_shaping();
        t_relock_and_free();
        t_bad_address();
        t_hard_lock();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule